// File: doc/BRIEF.md
# Decimal Accumulator Processor Core

This block is a small processor core. It has one accumulator and a decimal instruction set, and it runs over a private store of one hundred words. Each word holds a value from 0 to 999. The leading decimal digit of a word selects the operation. The two trailing digits give a direct memory address. The core steps through fetch, decode and execute phases. It keeps a program counter, an instruction register, a memory address register and a memory data register, along with a zero flag and a "high half" flag. All arithmetic is ten's complement and wraps modulo 1000. Every value is held as non-negative.

Software fills the store through a load port, usually while reset is held. When reset is released, execution begins at address 0. An input instruction makes the core wait for a value on a valid-qualified input port. An output instruction presents the accumulator for exactly one cycle. A halt instruction stops the core. An illegal code also stops it and raises a fault flag as well.

Top module: `dac_core`

## Requirements
- R1: During reset, `halted`, `fault`, `out_valid` and `in_ready` are 0, and ACC and PC are 0. The first fetch reads address 0 at the first rising edge after reset falls. If that word is an input instruction, `in_ready` is seen high after the third such edge.
- R2: A word is decoded as opcode = word / 100 and operand address = word mod 100. Code 1aa adds memory word aa into ACC modulo 1000.
- R3: Code 2aa sets ACC to (ACC + 1000 − mem[aa]) mod 1000.
- R4: Code 5aa copies mem[aa] into ACC. Code 3aa writes ACC into mem[aa].
- R5: Code 901 raises `in_ready` and stalls until `in_valid` is seen high. It then loads `in_data` mod 1000 into ACC.
- R6: Code 902 raises `out_valid` for exactly one cycle, with `out_data` equal to ACC. For a program of 901, then an arithmetic instruction, then 902, the pulse is seen 8 cycles after the cycle that accepts the input.
- R7: The zero flag is 1 exactly when ACC is 0, after every ACC update. Code 7aa jumps to aa when the flag is 1.
- R8: The high-half flag is 1 exactly when ACC ≥ 500. Code 8aa jumps to aa when ACC < 500, which is the non-negative range.
- R9: Code 6aa always jumps to aa. The PC counts upward and wraps from 99 to 0.
- R10: Any 0aa word stops the core. `halted` is then 1 and stays 1 until reset, with `fault` 0, and no further input or output occurs.
- R11: Opcode 4, and any 9aa other than 901 and 902, stops the core with both `halted` and `fault` at 1.
- R12: A `ld_en` cycle writes `ld_data` mod 1000 into word `ld_addr`. The load port has priority over a store by the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe for the program store |
| ld_addr | input | 7 | Word address for the load |
| ld_data | input | 10 | Value to load, reduced mod 1000 |
| in_valid | input | 1 | Input value is present |
| in_data | input | 10 | Input value, reduced mod 1000 |
| in_ready | output | 1 | Core is waiting for input |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 10 | Accumulator value for the output strobe |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Stop was caused by an illegal code |

## Verification
An input instruction that starts at the first edge after reset shows `in_ready` after the third edge. Memory-operand arithmetic takes five edges, and an output instruction takes three, so the output strobe of an input-compute-output program comes eight cycles after the input is accepted. The bench counts those cycles exactly, sampling at falling edges. It checks that the strobe is gone one cycle later. Branch, halt and fault programs are checked only by the values and flags they produce. Each of those checks polls at falling edges against a bounded wait.

// File: rtl/dac_pkg.sv
package dac_pkg;

    localparam int unsigned WORD_MAX  = 1000;
    localparam int unsigned ADDR_SPAN = 100;
    localparam int unsigned P_LIMIT   = 500;
    localparam int unsigned WORD_W    = $clog2(WORD_MAX);
    localparam int unsigned ADDR_W    = $clog2(ADDR_SPAN);
    localparam int unsigned OPC_W     = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WORD_W:0]   wide_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam wide_t WRAP_K   = wide_t'(WORD_MAX);
    localparam word_t HIGH_K   = word_t'(P_LIMIT);
    localparam word_t OP_RADIX = word_t'(ADDR_SPAN);
    localparam addr_t IO_IN    = addr_t'(1);
    localparam addr_t IO_OUT   = addr_t'(2);

    typedef enum logic [OPC_W-1:0] {
        OPC_HLT = 4'd0,
        OPC_ADD = 4'd1,
        OPC_SUB = 4'd2,
        OPC_STA = 4'd3,
        OPC_RSV = 4'd4,
        OPC_LDA = 4'd5,
        OPC_BRA = 4'd6,
        OPC_BRZ = 4'd7,
        OPC_BRP = 4'd8,
        OPC_IO  = 4'd9
    } opc_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEMRD,
        ST_ALU,
        ST_MEMWR,
        ST_INWAIT,
        ST_STOP
    } state_t;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB
    } alu_op_t;

    typedef struct packed {
        opc_t  opc;
        addr_t addr;
    } instr_t;

    // Fold a value below 2*WORD_MAX back into 0..WORD_MAX-1.
    function automatic word_t wrap_word(input wide_t v);
        wide_t t;
        t = (v >= WRAP_K) ? (v - WRAP_K) : v;
        return word_t'(t);
    endfunction

    function automatic instr_t split_instr(input word_t w);
        instr_t r;
        r.opc  = opc_t'(OPC_W'(w / OP_RADIX));
        r.addr = addr_t'(w % OP_RADIX);
        return r;
    endfunction

    function automatic addr_t next_pc(input addr_t pc, input addr_t last);
        return (pc >= last) ? '0 : addr_t'(pc + addr_t'(1));
    endfunction

endpackage

// File: rtl/dac_mem.sv
module dac_mem
    import dac_pkg::*;
#(
    parameter int unsigned DEPTH = ADDR_SPAN
) (
    input  logic  clk,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t raddr,
    output word_t rdata
);

    localparam addr_t LIMIT = addr_t'(DEPTH);

    word_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr < LIMIT)) begin
            cells[waddr] <= wdata;
        end
        rdata <= (raddr < LIMIT) ? cells[raddr] : '0;
    end

endmodule

// File: rtl/dac_alu.sv
module dac_alu
    import dac_pkg::*;
(
    input  alu_op_t op,
    input  word_t   acc,
    input  word_t   opd,
    output word_t   res,
    output logic    zero,
    output logic    high
);

    wide_t sum;

    always_comb begin
        unique case (op)
            ALU_ADD: sum = wide_t'(acc) + wide_t'(opd);
            ALU_SUB: sum = wide_t'(acc) + WRAP_K - wide_t'(opd);
            default: sum = wide_t'(opd);
        endcase
        res  = wrap_word(sum);
        zero = (res == '0);
        high = (res >= HIGH_K);
    end

endmodule

// File: rtl/dac_seq.sv
module dac_seq
    import dac_pkg::*;
#(
    parameter int unsigned ADDR_N = ADDR_SPAN
) (
    input  logic    clk,
    input  logic    rst,
    input  word_t   mem_rdata,
    output addr_t   mem_raddr,
    output logic    st_we,
    output addr_t   st_addr,
    output word_t   st_data,
    output alu_op_t alu_op,
    output word_t   alu_opd,
    input  word_t   alu_res,
    input  logic    alu_zero,
    input  logic    alu_high,
    input  logic    in_valid,
    input  word_t   in_data,
    output logic    in_ready,
    output logic    out_valid,
    output word_t   out_data,
    output logic    halted,
    output logic    fault,
    output word_t   acc,
    output addr_t   pc,
    output logic    zf,
    output logic    pf
);

    localparam addr_t PC_LAST = addr_t'(ADDR_N - 1);

    state_t state_q;
    instr_t cir_q;
    addr_t  pc_q;
    addr_t  mar_q;
    word_t  mdr_q;
    word_t  acc_q;
    logic   zf_q;
    logic   pf_q;
    logic   outv_q;
    word_t  outd_q;
    logic   halt_q;
    logic   fault_q;

    // Read port: instruction fetch uses PC, everything else uses MAR.
    assign mem_raddr = (state_q == ST_FETCH) ? pc_q : mar_q;
    assign st_we     = (state_q == ST_MEMWR);
    assign st_addr   = mar_q;
    assign st_data   = mdr_q;

    always_comb begin
        alu_op  = ALU_PASS;
        alu_opd = mdr_q;
        if (state_q == ST_INWAIT) begin
            alu_opd = in_data;
        end else begin
            unique case (cir_q.opc)
                OPC_ADD: alu_op = ALU_ADD;
                OPC_SUB: alu_op = ALU_SUB;
                default: alu_op = ALU_PASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            cir_q   <= '{opc: OPC_HLT, addr: '0};
            pc_q    <= '0;
            mar_q   <= '0;
            mdr_q   <= '0;
            acc_q   <= '0;
            zf_q    <= 1'b1;
            pf_q    <= 1'b0;
            outv_q  <= 1'b0;
            outd_q  <= '0;
            halt_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            outv_q <= 1'b0;
            unique case (state_q)
                ST_FETCH: begin
                    mar_q   <= pc_q;
                    pc_q    <= next_pc(pc_q, PC_LAST);
                    state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    cir_q   <= split_instr(mem_rdata);
                    mar_q   <= split_instr(mem_rdata).addr;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    state_q <= ST_FETCH;
                    unique case (cir_q.opc)
                        OPC_ADD, OPC_SUB, OPC_LDA: state_q <= ST_MEMRD;
                        OPC_STA: begin
                            mdr_q   <= acc_q;
                            state_q <= ST_MEMWR;
                        end
                        OPC_BRA: pc_q <= mar_q;
                        OPC_BRZ: if (zf_q) pc_q <= mar_q;
                        OPC_BRP: if (!pf_q) pc_q <= mar_q;
                        OPC_IO: begin
                            if (cir_q.addr == IO_IN) begin
                                state_q <= ST_INWAIT;
                            end else if (cir_q.addr == IO_OUT) begin
                                outv_q <= 1'b1;
                                outd_q <= acc_q;
                            end else begin
                                halt_q  <= 1'b1;
                                fault_q <= 1'b1;
                                state_q <= ST_STOP;
                            end
                        end
                        OPC_HLT: begin
                            halt_q  <= 1'b1;
                            state_q <= ST_STOP;
                        end
                        default: begin
                            halt_q  <= 1'b1;
                            fault_q <= 1'b1;
                            state_q <= ST_STOP;
                        end
                    endcase
                end
                ST_MEMRD: begin
                    mdr_q   <= mem_rdata;
                    state_q <= ST_ALU;
                end
                ST_ALU: begin
                    acc_q   <= alu_res;
                    zf_q    <= alu_zero;
                    pf_q    <= alu_high;
                    state_q <= ST_FETCH;
                end
                ST_MEMWR: begin
                    state_q <= ST_FETCH;
                end
                ST_INWAIT: begin
                    if (in_valid) begin
                        acc_q   <= alu_res;
                        zf_q    <= alu_zero;
                        pf_q    <= alu_high;
                        state_q <= ST_FETCH;
                    end
                end
                default: begin
                    state_q <= ST_STOP;
                end
            endcase
        end
    end

    assign in_ready  = (state_q == ST_INWAIT);
    assign out_valid = outv_q;
    assign out_data  = outd_q;
    assign halted    = halt_q;
    assign fault     = fault_q;
    assign acc       = acc_q;
    assign pc        = pc_q;
    assign zf        = zf_q;
    assign pf        = pf_q;

endmodule

// File: rtl/dac_core.sv
module dac_core
    import dac_pkg::*;
#(
    parameter int unsigned MEM_WORDS = ADDR_SPAN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              halted,
    output logic              fault
);

    word_t   mem_rdata;
    addr_t   mem_raddr;
    logic    st_we;
    addr_t   st_addr;
    word_t   st_data;
    logic    wr_en;
    addr_t   wr_addr;
    word_t   wr_data;
    alu_op_t alu_op;
    word_t   alu_opd;
    word_t   alu_res;
    logic    alu_zero;
    logic    alu_high;
    word_t   acc_w;
    addr_t   pc_w;
    logic    zf_w;
    logic    pf_w;

    // The load port wins over a store issued by the core in the same cycle.
    assign wr_en   = ld_en | st_we;
    assign wr_addr = ld_en ? ld_addr : st_addr;
    assign wr_data = ld_en ? wrap_word({1'b0, ld_data}) : st_data;

    dac_mem #(.DEPTH(MEM_WORDS)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dac_alu u_alu (
        .op   (alu_op),
        .acc  (acc_w),
        .opd  (alu_opd),
        .res  (alu_res),
        .zero (alu_zero),
        .high (alu_high)
    );

    dac_seq #(.ADDR_N(MEM_WORDS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_raddr (mem_raddr),
        .st_we     (st_we),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .alu_op    (alu_op),
        .alu_opd   (alu_opd),
        .alu_res   (alu_res),
        .alu_zero  (alu_zero),
        .alu_high  (alu_high),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .halted    (halted),
        .fault     (fault),
        .acc       (acc_w),
        .pc        (pc_w),
        .zf        (zf_w),
        .pf        (pf_w)
    );

endmodule

// File: rtl/dac_core_chk.sv
module dac_core_chk
    import dac_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  in_valid,
    input logic  in_ready,
    input logic  out_valid,
    input logic  halted,
    input logic  fault,
    input word_t acc,
    input addr_t pc,
    input logic  zf,
    input logic  pf
);

    localparam word_t ACC_LIM = word_t'(WORD_MAX);
    localparam addr_t PC_LIM  = addr_t'(ADDR_SPAN);

    p_acc_range_r2: assert property (@(posedge clk) disable iff (rst)
        acc < ACC_LIM);

    p_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready);

    p_out_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
        zf == (acc == '0));

    p_high_flag_r8: assert property (@(posedge clk) disable iff (rst)
        pf == (acc >= HIGH_K));

    p_pc_range_r9: assert property (@(posedge clk) disable iff (rst)
        pc < PC_LIM);

    p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(acc) && $stable(pc)));

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!in_ready && !out_valid));

    p_fault_halt_r11: assert property (@(posedge clk) disable iff (rst)
        fault |-> halted);

endmodule

bind dac_core dac_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .halted    (halted),
    .fault     (fault),
    .acc       (acc_w),
    .pc        (pc_w),
    .zf        (zf_w),
    .pf        (pf_w)
);

// File: tb/sim_dac_core.sv
`timescale 1ns/1ps
module sim_dac_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [6:0] ld_addr = '0;
    logic [9:0] ld_data = '0;
    logic       in_valid = 1'b0;
    logic [9:0] in_data = '0;
    logic       in_ready;
    logic       out_valid;
    logic [9:0] out_data;
    logic       halted;
    logic       fault;

    int n_chk = 0;
    int n_fail = 0;
    int img [100];

    // Vectors: opcode digit, input value, operand word, expected output.
    localparam int NVEC = 8;
    localparam int VEC [NVEC][4] = '{
        '{1, 123, 456, 579},
        '{1, 999,   1,   0},
        '{1, 600, 700, 300},
        '{2,   5,   7, 998},
        '{2, 500, 500,   0},
        '{5,  12, 777, 777},
        '{1, 1023,  0,  23},
        '{2,   0, 999,   1}
    };

    always #2 clk = ~clk;

    dac_core u0 (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .halted    (halted),
        .fault     (fault)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int a = 0; a < 100; a++) img[a] = 0;
    endtask

    // Hold reset, load the whole image, release reset at a falling edge.
    task automatic boot();
        @(negedge clk);
        rst = 1'b1;
        for (int a = 0; a < 100; a++) begin
            ld_en = 1'b1;
            ld_addr = 7'(a);
            ld_data = 10'(img[a]);
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic feed(input string req, input int v, input int hold);
        int k;
        for (k = 0; k < 200; k++) begin
            if (in_ready) break;
            @(negedge clk);
        end
        if (k == 200) check(req, "input wait timeout", 0, 1);
        repeat (hold) begin
            @(negedge clk);
            if (!in_ready || out_valid) check(req, "stall held", 0, 1);
        end
        in_valid = 1'b1;
        in_data = 10'(v);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_out(input string req, output int val, output int lat);
        val = -1;
        lat = -1;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            if (out_valid) begin
                val = int'(out_data);
                lat = k;
                @(negedge clk);
                check(req, "strobe one cycle", int'(out_valid), 0);
                return;
            end
        end
        check(req, "output timeout", 0, 1);
    endtask

    task automatic wait_halt(input string req, input int exp_fault);
        int k;
        for (k = 0; k < 200; k++) begin
            @(negedge clk);
            if (halted) break;
        end
        check(req, "halted", int'(halted), 1);
        check(req, "fault", int'(fault), exp_fault);
    endtask

    initial begin
        int v, lat;
        string tag;

        // R1: state while reset is held
        repeat (3) @(negedge clk);
        check("R1", "halted in reset", int'(halted), 0);
        check("R1", "fault in reset", int'(fault), 0);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "in_ready in reset", int'(in_ready), 0);

        // Vector table: 901, op 10, 902, halt; word 10 holds the operand
        for (int i = 0; i < NVEC; i++) begin
            tag = (VEC[i][0] == 1) ? "R2" : (VEC[i][0] == 2) ? "R3" : "R4";
            clear_img();
            img[0] = 901;
            img[1] = VEC[i][0] * 100 + 10;
            img[2] = 902;
            img[3] = 0;
            img[10] = VEC[i][2];
            boot();
            if (i == 0) begin
                // R1: in_ready is seen after the third edge following release
                @(negedge clk);
                check("R1", "in_ready after edge 1", int'(in_ready), 0);
                @(negedge clk);
                check("R1", "in_ready after edge 2", int'(in_ready), 0);
                @(negedge clk);
                check("R1", "in_ready after edge 3", int'(in_ready), 1);
            end
            feed("R5", VEC[i][1], (i == 0) ? 20 : 0);
            wait_out(tag, v, lat);
            check(tag, "result", v, VEC[i][3]);
            check("R6", "latency", lat, 8);
            wait_halt("R10", 0);
            repeat (10) begin
                @(negedge clk);
                if (out_valid || in_ready) check("R10", "quiet after halt", 1, 0);
            end
        end

        // R4: store then reload
        clear_img();
        img[0] = 901; img[1] = 320; img[2] = 521; img[3] = 520;
        img[4] = 902; img[5] = 0;   img[21] = 5;
        boot();
        feed("R4", 345, 0);
        wait_out("R4", v, lat);
        check("R4", "stored value reloaded", v, 345);

        // R7: zero-flag branch, taken and not taken
        for (int t = 0; t < 2; t++) begin
            clear_img();
            img[0] = 901; img[1] = 704; img[2] = 902; img[3] = 0;
            img[4] = 509; img[5] = 902; img[6] = 0;   img[9] = 111;
            boot();
            feed("R7", (t == 0) ? 0 : 7, 0);
            wait_out("R7", v, lat);
            check("R7", "zero branch", v, (t == 0) ? 111 : 7);
        end

        // R8: high-half branch at 0, 499 and 500
        for (int t = 0; t < 3; t++) begin
            int inp;
            inp = (t == 0) ? 0 : (t == 1) ? 499 : 500;
            clear_img();
            img[0] = 901; img[1] = 804; img[2] = 902; img[3] = 0;
            img[4] = 509; img[5] = 902; img[6] = 0;   img[9] = 111;
            boot();
            feed("R8", inp, 0);
            wait_out("R8", v, lat);
            check("R8", "positive branch", v, (t == 2) ? 500 : 111);
        end

        // R9: jump to 98, output, load, wrap past 99 back to 0
        clear_img();
        img[0] = 698; img[98] = 902; img[99] = 509; img[9] = 111;
        boot();
        wait_out("R9", v, lat);
        check("R9", "first output", v, 0);
        wait_out("R9", v, lat);
        check("R9", "output after wrap", v, 111);

        // R11: reserved opcode and undefined I/O code
        clear_img();
        img[0] = 400;
        boot();
        wait_halt("R11", 1);
        clear_img();
        img[0] = 903;
        boot();
        wait_halt("R11", 1);

        // R12: loaded value above 999 is reduced
        clear_img();
        img[0] = 509; img[1] = 902; img[2] = 0; img[9] = 1005;
        boot();
        wait_out("R12", v, lat);
        check("R12", "load reduced", v, 5);

        summary();
        $finish;
    end

endmodule